// File: doc/BRIEF.md
# Clock Synchroniser Holdover Word Store

This block sits between the loop filter of a digital clock synchroniser and the numerically controlled oscillator that makes the output clock. It picks which frequency control word drives that oscillator. A two-bit mode input selects one of four operating modes:

- a normal mode that drops into holdover by itself;
- a forced holdover mode;
- a freerun mode;
- an automatic mode, where an outside controller may request holdover.

In a normal state with the loop locked, the live loop word passes straight through to the output. In freerun, the output is a fixed nominal word, so output timing rests on the master clock alone.

While the loop stays locked in a normal state, a prescaler on the system clock marks one storage period, which is 26 ms in a real system. At each mark the live word is captured. Captures alternate between two slots. When holdover begins, the block hands the oscillator the older of the two captures. That capture is between one and two periods old, so a disturbance in the last moments before the switch does not reach the held frequency.

The phase detector, the loop filter, reference qualification and the reference-choosing controller lie outside this block. Their results arrive as the inputs `ref_locked`, `loop_word` and `ext_hold_req`.

Top module: `hfs_top`

## Requirements
- R1: Reset state: `freq_word` equals the nominal word, `op_state` is 2'b10 (freerun), `holdover_active` is 0, and both slots are empty.
- R2: With `mode_sel` = 2'b00 and `ref_locked` = 1, `op_state` is 2'b00 (normal) and `freq_word` equals the `loop_word` seen at the previous clock edge.
- R3: With `mode_sel` = 2'b00 and `ref_locked` = 0, the block is in holdover (`op_state` 2'b01, `holdover_active` 1). With `mode_sel` = 2'b11 it is in holdover when `ext_hold_req` = 1 or `ref_locked` = 0, and in normal otherwise. `op_state` is never 2'b11.
- R4: With `mode_sel` = 2'b01 the block is in holdover, whatever the value of `ref_locked`.
- R5: With `mode_sel` = 2'b10 the block is in freerun: `op_state` is 2'b10, `holdover_active` is 0, and `freq_word` is the nominal word, whatever the values of `loop_word` and `ref_locked`.
- R6: A capture happens at the PERIOD-th consecutive clock edge spent in the normal state, and again after every further PERIOD edges. Any edge outside the normal state restarts this count.
- R7: Captures go to slot 0 first and then alternate between the slots. On entry to holdover with both slots filled, `freq_word` takes the slot that was not written last.
- R8: On entry to holdover with only one slot filled, `freq_word` takes that slot. With no slot filled, it takes the nominal word.
- R9: No capture happens outside the normal state. The slots keep their contents across holdover and freerun, and a later holdover entry returns the same older word.
- R10: While holdover lasts, `freq_word` stays fixed even if `loop_word` changes.
- R11: All outputs are registered. A change on a mode or lock input shows at the outputs after the next clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 00 normal with automatic holdover, 01 holdover, 10 freerun, 11 automatic |
| ext_hold_req | input | 1 | Holdover request from the reference controller; only used in mode 11 |
| ref_locked | input | 1 | The loop is locked to its reference |
| loop_word | input | W | Live frequency word from the loop filter |
| freq_word | output | W | Word driving the output oscillator |
| op_state | output | 2 | Current state: 00 normal, 01 holdover, 10 freerun |
| holdover_active | output | 1 | High while in holdover |

## Verification
The assertions assume that `mode_sel`, `ref_locked` and `ext_hold_req` are synchronous to `clk` and settle before each rising edge. The bench respects this by changing every input on the falling edge. The assertion on captures also assumes that the slots change only at a capture. The stimulus builds on that: it changes `loop_word` during holdover and freerun, and then checks at a later holdover entry that the stored older word is still there.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL = 2'b00,
      ST_HOLD   = 2'b01,
      ST_FREE   = 2'b10
   } op_state_e;

   localparam logic [1:0] SEL_AUTO_HOLD = 2'b00;
   localparam logic [1:0] SEL_HOLD      = 2'b01;
   localparam logic [1:0] SEL_FREE      = 2'b10;
   localparam logic [1:0] SEL_AUTO      = 2'b11;

   // number of history slots; holdover reads the older one
   localparam int unsigned NSLOT = 2;

   // 2^-24 is about 0.06 ppm, finer than the 0.1 ppm holdover target
   localparam int unsigned MIN_WORD_W = 24;

endpackage

// File: rtl/hfs_mode_decode.sv
module hfs_mode_decode
   import hfs_pkg::*;
(
   input  logic [1:0] mode_sel,
   input  logic       ext_hold_req,
   input  logic       ref_locked,
   output op_state_e  next_state
);

   always_comb begin
      unique case (mode_sel)
         SEL_AUTO_HOLD: next_state = ref_locked ? ST_NORMAL : ST_HOLD;
         SEL_HOLD:      next_state = ST_HOLD;
         SEL_FREE:      next_state = ST_FREE;
         default:       next_state = (ref_locked && !ext_hold_req) ? ST_NORMAL : ST_HOLD;
      endcase
   end

endmodule

// File: rtl/hfs_cap_timer.sv
module hfs_cap_timer #(
   parameter int unsigned PERIOD = 520000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("hfs_cap_timer: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("capture marks too close together"); // R6

endmodule

// File: rtl/hfs_slot_bank.sv
module hfs_slot_bank
   import hfs_pkg::*;
#(
   parameter int unsigned W = 24,
   parameter logic [W-1:0] NOMINAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_en,
   input  logic [W-1:0] cap_word,
   output logic [W-1:0] old_word
);

   localparam int unsigned PW = $clog2(NSLOT);

   logic [W-1:0] slot_q [NSLOT];
   logic [NSLOT-1:0] vld_q;
   logic [PW-1:0] wr_ptr_q;
   logic [NSLOT*W-1:0] slot_flat;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[g] <= '0;
               vld_q[g]  <= 1'b0;
            end else if (cap_en && (wr_ptr_q == PW'(g))) begin
               slot_q[g] <= cap_word;
               vld_q[g]  <= 1'b1;
            end
         end
         assign slot_flat[g*W +: W] = slot_q[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
      end else if (cap_en) begin
         wr_ptr_q <= wr_ptr_q + 1'b1;
      end
   end

   // the slot due to be written next is the older one
   always_comb begin
      if (vld_q[wr_ptr_q]) begin
         old_word = slot_q[wr_ptr_q];
      end else if (vld_q[0]) begin
         old_word = slot_q[0];
      end else begin
         old_word = NOMINAL;
      end
   end

   AST_SLOTS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(slot_flat)) else $error("slot changed without capture"); // R9
   AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (wr_ptr_q != $past(wr_ptr_q))) else $error("slot pointer did not advance"); // R7

endmodule

// File: rtl/hfs_top.sv
module hfs_top
   import hfs_pkg::*;
#(
   parameter int unsigned  W       = 24,
   parameter int unsigned  PERIOD  = 520000,
   parameter logic [W-1:0] NOMINAL = W'(1) << (W - 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode_sel,
   input  logic         ext_hold_req,
   input  logic         ref_locked,
   input  logic [W-1:0] loop_word,
   output logic [W-1:0] freq_word,
   output logic [1:0]   op_state,
   output logic         holdover_active
);

   generate
      if (W < MIN_WORD_W) begin : g_bad_width
         $error("hfs_top: W too narrow for 0.1 ppm holdover resolution");
      end
   endgenerate

   op_state_e    nxt_state;
   op_state_e    state_q;
   logic         hold_q;
   logic         tick;
   logic         cap_en;
   logic [W-1:0] old_word;
   logic [W-1:0] freq_q;

   hfs_mode_decode u_dec (
      .mode_sel     (mode_sel),
      .ext_hold_req (ext_hold_req),
      .ref_locked   (ref_locked),
      .next_state   (nxt_state)
   );

   hfs_cap_timer #(.PERIOD(PERIOD)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (nxt_state == ST_NORMAL),
      .tick  (tick)
   );

   assign cap_en = tick;

   hfs_slot_bank #(.W(W), .NOMINAL(NOMINAL)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_word (loop_word),
      .old_word (old_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FREE;
         hold_q  <= 1'b0;
         freq_q  <= NOMINAL;
      end else begin
         state_q <= nxt_state;
         hold_q  <= (nxt_state == ST_HOLD);
         unique case (nxt_state)
            ST_NORMAL: freq_q <= loop_word;
            ST_HOLD:   if (!hold_q) freq_q <= old_word;
            default:   freq_q <= NOMINAL;
         endcase
      end
   end

   assign freq_word       = freq_q;
   assign op_state        = state_q;
   assign holdover_active = hold_q;

   AST_FREE_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FREE) |-> (freq_q == NOMINAL)) else $error("freerun word off nominal"); // R5
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && $past(hold_q)) |-> $stable(freq_q)) else $error("holdover word moved"); // R10
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != 2'b11)) else $error("illegal state code"); // R3
   AST_NO_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == SEL_HOLD || mode_sel == SEL_FREE) |-> !cap_en) else $error("capture outside normal"); // R9

endmodule

// File: tb/hfs_top_tb.sv
module hfs_top_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int unsigned W = 24;
   localparam int unsigned PER = 4;
   localparam logic [W-1:0] NOM = 24'h800000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b10;
   logic ext_hold_req = 1'b0;
   logic ref_locked = 1'b0;
   logic [W-1:0] loop_word = '0;
   logic [W-1:0] freq_word;
   logic [1:0] op_state;
   logic holdover_active;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hfs_top #(.W(W), .PERIOD(PER), .NOMINAL(NOM)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_sel        (mode_sel),
      .ext_hold_req    (ext_hold_req),
      .ref_locked      (ref_locked),
      .loop_word       (loop_word),
      .freq_word       (freq_word),
      .op_state        (op_state),
      .holdover_active (holdover_active)
   );

   typedef struct packed {
      logic [1:0]   m;
      logic         lk;
      logic         hr;
      logic [W-1:0] w;
      logic [3:0]   n;
      logic [W-1:0] ew;
      logic [1:0]   es;
      logic         eh;
      logic [3:0]   rq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b1, 1'b0, 24'h100000, 4'd1, 24'h100000, 2'b00, 1'b0, 4'd2},  // R2 pass-through
      '{2'b01, 1'b1, 1'b0, 24'h100000, 4'd1, NOM,        2'b01, 1'b1, 4'd8},  // R8 no slot -> nominal
      '{2'b00, 1'b1, 1'b0, 24'h200000, 4'd4, 24'h200000, 2'b00, 1'b0, 4'd6},  // R6 capture B into slot 0
      '{2'b01, 1'b1, 1'b0, 24'h200000, 4'd1, 24'h200000, 2'b01, 1'b1, 4'd8},  // R8 single slot used
      '{2'b01, 1'b1, 1'b0, 24'h300000, 4'd3, 24'h200000, 2'b01, 1'b1, 4'd10}, // R10 frozen
      '{2'b00, 1'b1, 1'b0, 24'h300000, 4'd4, 24'h300000, 2'b00, 1'b0, 4'd6},  // R6 capture C into slot 1
      '{2'b00, 1'b1, 1'b0, 24'h400000, 4'd4, 24'h400000, 2'b00, 1'b0, 4'd7},  // R7 capture D into slot 0
      '{2'b00, 1'b0, 1'b0, 24'h500000, 4'd1, 24'h300000, 2'b01, 1'b1, 4'd7},  // R7 older slot, R3 auto
      '{2'b10, 1'b1, 1'b0, 24'h500000, 4'd1, NOM,        2'b10, 1'b0, 4'd5},  // R5 freerun
      '{2'b11, 1'b1, 1'b0, 24'h500000, 4'd3, 24'h500000, 2'b00, 1'b0, 4'd3},  // R3 auto mode normal
      '{2'b11, 1'b1, 1'b1, 24'h500000, 4'd1, 24'h300000, 2'b01, 1'b1, 4'd3},  // R3 requested holdover
      '{2'b11, 1'b0, 1'b0, 24'h700000, 4'd1, 24'h300000, 2'b01, 1'b1, 4'd3},  // R3 unlocked holdover
      '{2'b00, 1'b1, 1'b0, 24'h600000, 4'd2, 24'h600000, 2'b00, 1'b0, 4'd2},  // R2 back to normal
      '{2'b01, 1'b0, 1'b0, 24'h600000, 4'd1, 24'h300000, 2'b01, 1'b1, 4'd4}   // R4 and R9 slots kept
   };

   task automatic check(input string tag, input logic [W-1:0] ew, input logic [1:0] es, input logic eh);
      n_vec++;
      if (freq_word !== ew || op_state !== es || holdover_active !== eh) begin
         n_bad++;
         $display("FAIL %s: got word %h state %b hold %b, expected word %h state %b hold %b",
                  tag, freq_word, op_state, holdover_active, ew, es, eh);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset state", NOM, 2'b10, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         mode_sel     = VECS[i].m;
         ref_locked   = VECS[i].lk;
         ext_hold_req = VECS[i].hr;
         loop_word    = VECS[i].w;
         repeat (int'(VECS[i].n)) @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].ew, VECS[i].es, VECS[i].eh);
      end

      // R11: input change is not visible before the next edge
      mode_sel = 2'b10;
      #1;
      check("R11 before edge", 24'h300000, 2'b01, 1'b1);
      @(negedge clk);
      check("R11 after edge", NOM, 2'b10, 1'b0);

      // R5: freerun ignores loop word and lock
      loop_word = 24'h0ABCDE;
      ref_locked = 1'b0;
      repeat (2) @(negedge clk);
      check("R5 freerun ignores inputs", NOM, 2'b10, 1'b0);

      // R6: three normal edges are not enough for a capture
      mode_sel = 2'b00; ref_locked = 1'b1; loop_word = 24'h111111;
      repeat (3) @(negedge clk);
      mode_sel = 2'b01;
      @(negedge clk);
      check("R6 no early capture", 24'h300000, 2'b01, 1'b1);

      // R1: reset clears the slots
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", NOM, 2'b10, 1'b0);
      rst_n = 1'b1;
      mode_sel = 2'b01;
      @(negedge clk);
      check("R8 empty after reset", NOM, 2'b01, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule